// File: doc/BRIEF.md
# Multi-Link Synchronization Point Controller

This block produces a periodic synchronization point shared by several serial audio bus links. At that point command traffic can change without disturbing the audio stream. A down-counter runs on the oscillator clock and reloads from a programmable period. Software picks the period to give a 4 kHz point from either a 24 MHz or a 38.4 MHz oscillator. Each link receives a strobe at the point, but only while that link reports that it is active.

The block also coordinates a bank switch across links. Software arms each link that should switch. It then issues a single go command. On the first synchronization point after the go, every armed and active link receives a one-cycle bank-switch pulse in the same cycle, and all arm bits clear.

A start bit is written together with the period. Hardware clears it once a link comes up, and software polls for that clear. Writes use a single-cycle valid/address/data strobe. Readback is combinational from a separate read address.

Top module: `sync_point_ctrl`

## Requirements
- R1: After reset, the period is 0, the start bit is 0, all arm bits are 0, and `sync_o` and `bank_o` are 0. Every readable register (address 0 config, 1 arm, 2 control) reads 0.
- R2: Config register (address 0) bits [PERIOD_W-1:0] hold the period P. For P > 0, the counter ticks every P cycles. The first tick appears P cycles after the write cycle, and later ticks follow every P cycles.
- R3: With P = 0 the counter is stopped and `sync_o` stays 0.
- R4: `sync_o[i]` is the tick qualified by `link_active_i[i]`. It is never high for an inactive link.
- R5: Config bit PERIOD_W is the start bit and is loaded on every config write. While it is set, it clears on the cycle after any `link_active_i` bit is high. While no link is active, it holds.
- R6: Writing address 1 sets arm bit i for each data bit i written as 1, where bit i belongs to link i. Bits written as 0 are untouched. The arm bits read back at address 1.
- R7: Control register (address 2) bit 0 is the go bit. It acts only when written as 1 and always reads 0. A go issued while no arm bit is set produces no bank pulse.
- R8: After a go, the first tick produces `bank_o[i]` for every armed link i that is active. This pulse is one cycle long and falls in the same cycle as `sync_o`.
- R9: Control register bit 1 reads 1 while any arm bit is set. All arm bits clear on the cycle of the bank pulse, so this bit then reads 0.
- R10: Writing a new period reloads the counter at once, discarding the remainder of the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_addr_i | input | 2 | Write address (0 config, 1 arm, 2 control) |
| wr_data_i | input | PERIOD_W+1 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | PERIOD_W+1 | Combinational read data |
| link_active_i | input | N_LINKS | Per-link active indication |
| sync_o | output | N_LINKS | Per-link synchronization point strobe |
| bank_o | output | N_LINKS | Per-link bank-switch pulse |

## Verification
The counter is tried with periods 3, 5, 8 and 1. Measuring both the first tick and the following interval separates a correct reload from an off-by-one and from a free-running count. The degenerate period of 1 checks the tick-every-cycle case. The bank switch is tried with a sparse arm pattern on all-active links, and again with a mix of active and inactive links, which tells arm masking apart from active masking. It is also tried with a go and nothing armed. A mid-count period change separates an immediate reload from a reload that waits for the old count to run out.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_ARM  = 2'd1,
    ADDR_CTRL = 2'd2
  } sp_addr_e;

  localparam int unsigned GO_BIT   = 0;
  localparam int unsigned PEND_BIT = 1;
endpackage

// File: rtl/sp_period_timer.sv
module sp_period_timer #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [PERIOD_W-1:0] load_val_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                run;

  assign run    = (period_i != '0);
  assign tick_o = run && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_i)     cnt_q <= (load_val_i == '0) ? '0 : load_val_i - PERIOD_W'(1);
    else if (run)        cnt_q <= tick_o ? period_i - PERIOD_W'(1) : cnt_q - PERIOD_W'(1);
  end
endmodule

// File: rtl/sp_cfg_reg.sv
module sp_cfg_reg #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [PERIOD_W:0]   wdata_i,
  input  logic                any_active_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic                start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= '0;
      start_o  <= 1'b0;
    end else if (wr_i) begin
      period_o <= wdata_i[PERIOD_W-1:0];
      start_o  <= wdata_i[PERIOD_W];
    end else if (any_active_i) begin
      start_o  <= 1'b0;  // self-clear once a link is up
    end
  end
endmodule

// File: rtl/sp_arm_go.sv
module sp_arm_go #(
  parameter int unsigned N_LINKS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_arm_i,
  input  logic               wr_go_i,
  input  logic [N_LINKS-1:0] set_i,
  input  logic               tick_i,
  input  logic [N_LINKS-1:0] link_active_i,
  output logic [N_LINKS-1:0] arm_o,
  output logic               pend_o,
  output logic [N_LINKS-1:0] bank_o
);
  logic [N_LINKS-1:0] arm_q, arm_nxt;
  logic               go_q, go_nxt, release_now;

  assign release_now = go_q && tick_i;

  always_comb begin
    arm_nxt = (release_now ? '0 : arm_q) | (wr_arm_i ? set_i : '0);
    go_nxt  = (release_now ? 1'b0 : go_q) | (wr_go_i && (arm_nxt != '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= '0;
      go_q  <= 1'b0;
    end else begin
      arm_q <= arm_nxt;
      go_q  <= go_nxt;
    end
  end

  for (genvar i = 0; i < N_LINKS; i++) begin : g_bank
    assign bank_o[i] = release_now && arm_q[i] && link_active_i[i];
  end

  assign arm_o  = arm_q;
  assign pend_o = go_q;
endmodule

// File: rtl/sync_point_ctrl.sv
module sync_point_ctrl #(
  parameter int unsigned N_LINKS  = 4,
  parameter int unsigned PERIOD_W = 16,
  localparam int unsigned DATA_W  = PERIOD_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [1:0]         rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [N_LINKS-1:0] link_active_i,
  output logic [N_LINKS-1:0] sync_o,
  output logic [N_LINKS-1:0] bank_o
);
  import sp_pkg::*;

  logic                wr_cfg, wr_arm, wr_go, tick;
  logic [PERIOD_W-1:0] period_q;
  logic                start_q, go_pend;
  logic [N_LINKS-1:0]  arm_q;

  assign wr_cfg = wr_en_i && (wr_addr_i == ADDR_CFG);
  assign wr_arm = wr_en_i && (wr_addr_i == ADDR_ARM);
  assign wr_go  = wr_en_i && (wr_addr_i == ADDR_CTRL) && wr_data_i[GO_BIT];

  sp_cfg_reg #(.PERIOD_W(PERIOD_W)) u_cfg (
    .clk_i, .rst_ni,
    .wr_i         (wr_cfg),
    .wdata_i      (wr_data_i),
    .any_active_i (|link_active_i),
    .period_o     (period_q),
    .start_o      (start_q)
  );

  sp_period_timer #(.PERIOD_W(PERIOD_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i     (wr_cfg),
    .load_val_i (wr_data_i[PERIOD_W-1:0]),
    .period_i   (period_q),
    .tick_o     (tick)
  );

  sp_arm_go #(.N_LINKS(N_LINKS)) u_arm (
    .clk_i, .rst_ni,
    .wr_arm_i      (wr_arm),
    .wr_go_i       (wr_go),
    .set_i         (wr_data_i[N_LINKS-1:0]),
    .tick_i        (tick),
    .link_active_i (link_active_i),
    .arm_o         (arm_q),
    .pend_o        (go_pend),
    .bank_o        (bank_o)
  );

  assign sync_o = {N_LINKS{tick}} & link_active_i;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_CFG: begin
        rd_data_o[PERIOD_W-1:0] = period_q;
        rd_data_o[PERIOD_W]     = start_q;
      end
      ADDR_ARM:  rd_data_o[N_LINKS-1:0] = arm_q;
      ADDR_CTRL: rd_data_o[PEND_BIT]    = |arm_q;
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/sp_ctrl_chk.sv
module sp_ctrl_chk #(
  parameter int unsigned N_LINKS  = 4,
  parameter int unsigned PERIOD_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [1:0]          wr_addr_i,
  input logic [N_LINKS-1:0]  link_active_i,
  input logic [N_LINKS-1:0]  sync_o,
  input logic [N_LINKS-1:0]  bank_o,
  input logic [N_LINKS-1:0]  arm_q,
  input logic                go_pend,
  input logic [PERIOD_W-1:0] period_q,
  input logic                start_q
);
  logic wr_cfg, wr_arm, wr_go;
  assign wr_cfg = wr_en_i && (wr_addr_i == sp_pkg::ADDR_CFG);
  assign wr_arm = wr_en_i && (wr_addr_i == sp_pkg::ADDR_ARM);
  assign wr_go  = wr_en_i && (wr_addr_i == sp_pkg::ADDR_CTRL);

  a_r4_sync_only_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o & ~link_active_i) == '0);

  a_r3_stopped_no_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_q == '0) |-> (sync_o == '0));

  a_r8_bank_with_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_o & ~sync_o) == '0);

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_o != '0) |=> (bank_o == '0));

  a_r9_arm_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bank_o != '0) && !wr_arm) |=> (arm_q == '0));

  a_r7_go_without_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && (arm_q == '0) && !go_pend && !wr_arm) |=> !go_pend);

  a_r5_start_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && (link_active_i != '0) && !wr_cfg) |=> !start_q);
endmodule

bind sync_point_ctrl sp_ctrl_chk #(.N_LINKS(N_LINKS), .PERIOD_W(PERIOD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .link_active_i (link_active_i),
  .sync_o        (sync_o),
  .bank_o        (bank_o),
  .arm_q         (arm_q),
  .go_pend       (go_pend),
  .period_q      (period_q),
  .start_q       (start_q)
);

// File: tb/sim_sync_point_ctrl.sv
module sim_sync_point_ctrl;
  localparam int unsigned N  = 4;
  localparam int unsigned PW = 16;
  localparam int unsigned DW = PW + 1;
  localparam int unsigned NV = 4;
  localparam int unsigned VEC_P [NV] = '{3, 5, 8, 1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [N-1:0]  link_act = '0;
  logic [N-1:0]  sync_s, bank_s;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sync_point_ctrl #(.N_LINKS(N), .PERIOD_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .link_active_i(link_act), .sync_o(sync_s), .bank_o(bank_s)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // k = 1 at the current negedge; returns index of first tick seen
  task automatic wait_tick(output int k);
    k = 0;
    for (int i = 1; i <= 200; i++) begin
      if (sync_s != '0) begin k = i; return; end
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int k, k2;
    bit early, seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk(d == '0, "R1", "cfg", d, 0);
    rd(2'd1, d); chk(d == '0, "R1", "arm", d, 0);
    rd(2'd2, d); chk(d == '0, "R1", "ctrl", d, 0);
    chk(sync_s == '0 && bank_s == '0, "R1", "outputs", {sync_s, bank_s}, 0);

    // R5 start bit held with no link active, then self-clears
    wr(2'd0, DW'((1 << PW) | 10));
    rd(2'd0, d); chk(d == DW'((1 << PW) | 10), "R5", "start set", d, (1 << PW) | 10);
    repeat (5) @(negedge clk);
    rd(2'd0, d); chk(d[PW] == 1'b1, "R5", "start held", d[PW], 1);
    chk(sync_s == '0, "R4", "no strobe when inactive", sync_s, 0);
    @(negedge clk); link_act = 4'b0010;
    @(negedge clk);
    rd(2'd0, d); chk(d[PW] == 1'b0, "R5", "start cleared", d[PW], 0);
    link_act = 4'b1111;

    // R2 vector table: first tick and interval
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, DW'(VEC_P[v]));
      wait_tick(k);
      chk(k == int'(VEC_P[v]), "R2", "first tick", k, VEC_P[v]);
      @(negedge clk);
      wait_tick(k2);
      chk(k2 == int'(VEC_P[v]), "R2", "interval", k2, VEC_P[v]);
    end

    // R10 mid-count reload
    wr(2'd0, DW'(20));
    repeat (7) @(negedge clk);
    wr(2'd0, DW'(4));
    wait_tick(k);
    chk(k == 4, "R10", "reload first tick", k, 4);

    // R6/R8/R9 bank switch, all links active
    wr(2'd0, DW'(6));
    wr(2'd1, DW'(4'b0101));
    wr(2'd1, DW'(4'b0000));
    rd(2'd1, d); chk(d == DW'(4'b0101), "R6", "arm readback", d, 4'b0101);
    rd(2'd2, d); chk(d == DW'(2), "R9", "pending set, go reads 0", d, 2);
    wr(2'd2, DW'(1));
    early = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (sync_s != '0) break;
      if (bank_s != '0) early = 1'b1;
      @(negedge clk);
    end
    chk(bank_s == 4'b0101 && sync_s == 4'b1111, "R8", "bank at sync", bank_s, 4'b0101);
    chk(!early, "R8", "no early bank", early, 0);
    @(negedge clk);
    chk(bank_s == '0, "R8", "single pulse", bank_s, 0);
    rd(2'd1, d); chk(d == '0, "R9", "arm cleared", d, 0);
    rd(2'd2, d); chk(d == '0, "R9", "pending cleared", d, 0);

    // R4/R8 inactive links masked
    @(negedge clk); link_act = 4'b0011;
    wr(2'd1, DW'(4'b0111));
    wr(2'd2, DW'(1));
    wait_tick(k);
    chk(sync_s == 4'b0011, "R4", "sync qualified", sync_s, 4'b0011);
    chk(bank_s == 4'b0011, "R8", "bank qualified", bank_s, 4'b0011);
    @(negedge clk);
    rd(2'd1, d); chk(d == '0, "R9", "inactive arm cleared", d, 0);
    link_act = 4'b1111;

    // R7 go with nothing armed
    wr(2'd2, DW'(1));
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (bank_s != '0) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R7", "no bank without arm", seen, 0);
    rd(2'd2, d); chk(d[0] == 1'b0, "R7", "go reads zero", d[0], 0);

    // R3 zero period stops strobes
    wr(2'd0, '0);
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (sync_s != '0) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R3", "no strobe at period 0", seen, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule